// File: doc/BRIEF.md
# Accelerator Control and Parameter Register Bank

This block is an AXI4-Lite slave that sits between a host processor and a streaming image-processing core. Software uses it to launch the core, observe its progress and receive interrupts, and to hold the per-frame runtime parameters the core reads: frame width, frame height, four per-channel black-level offsets and a colour-filter pattern code. Each parameter is a full 32-bit register. Its value goes straight out to the core on a dedicated port.

The control registers have side effects. A start request stays pending until the core signals that it has taken it. A completion flag clears itself when software reads it. Interrupt status bits are flipped by writing ones to them. An auto-restart option relaunches the core each time it finishes. A single interrupt line is the global enable gated with the OR of the status bits.

Addresses are byte addresses. Bits [1:0] of both read and write addresses are ignored, so every access is a whole 32-bit word. All accesses complete with an OKAY response.

Top module: `accel_ctrl_regs`

## Requirements
- R1: While reset is applied and after it is released, with no access yet made: core_start and irq are low; awready, wready and arready are high; bvalid and rvalid are low; every register reads zero, except the live idle and ready bits of offset 0x00.
- R2: The write address and the write data may arrive in either order or in the same cycle.
  - A channel that has been accepted drops its ready until the write completes.
  - bvalid rises on the clock edge at which the second of the two is accepted.
  - bvalid is held until bready.
  - bresp is 2'b00 (OKAY).
- R3: rvalid rises on the clock edge after an accepted read address. rdata and rvalid are held unchanged until rready. rresp is 2'b00.
- R4: The parameter registers are 32 bits wide: width at 0x10, height at 0x18, red level at 0x20, blue level at 0x28, green-on-red-row level at 0x30, green-on-blue-row level at 0x38 and pattern code at 0x40. Each reads back what was written and drives its output port from the edge on which the write completes.
- R5: Reserved or unmapped offsets read zero, and writes to them change nothing. This covers 0x14, 0x1C, 0x24, 0x2C, 0x34, 0x3C, 0x44 and everything up to 0x7C.
- R6: At offset 0x00, writing 1 to bit 0 sets the start bit, which drives core_start. The bit clears on the edge at which core_ready is sampled high. Writing 0 to bit 0 does not clear it.
- R7: Bit 7 of offset 0x00 is auto-restart. It is read/write. While it is set, a core_done pulse sets the start bit again. While it is clear, core_done leaves start unchanged.
- R8: Bit 1 of offset 0x00 (done) is set by core_done. It is cleared by a read of 0x00, and that read still returns 1. If core_done and the clearing read fall on the same edge, done stays set. Bit 2 is core_idle and bit 3 is core_ready, both read live.
- R9: Offset 0x04 bit 0 is the global interrupt enable. Offset 0x08 bit 0 is the done-interrupt enable and bit 1 is the ready-interrupt enable. Both registers read back as written.
- R10: Offset 0x0C holds the interrupt status. Bit 0 is set by core_done when the done-interrupt enable is 1. Bit 1 is set by core_ready when the ready-interrupt enable is 1. Writing 1 to a bit inverts it, and writing 0 leaves it unchanged.
- R11: irq is high exactly when the global enable is 1 and at least one status bit is 1. It follows a change to either one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| core_start | output | 1 | Start request level to the core |
| core_done | input | 1 | Core finished a run (pulse) |
| core_idle | input | 1 | Core is idle (level) |
| core_ready | input | 1 | Core accepted a start (pulse) |
| irq | output | 1 | Interrupt request |
| cfg_width | output | DATA_W | Frame width parameter |
| cfg_height | output | DATA_W | Frame height parameter |
| cfg_lvl_red | output | DATA_W | Red black level |
| cfg_lvl_blue | output | DATA_W | Blue black level |
| cfg_lvl_gred | output | DATA_W | Green (red row) black level |
| cfg_lvl_gblue | output | DATA_W | Green (blue row) black level |
| cfg_pattern | output | DATA_W | Colour-filter pattern code |

## Verification
The control state is small, and each wrong internal bit reaches the ports within one access.
- A start bit that clears too early or too late shows as a wrong core_start level on the edge after core_ready or core_done.
- A done or status bit that fails to set, clear or toggle shows in the next read of 0x00 or 0x0C, and on irq one edge after the event.
- A channel held in the wrong state shows as a dropped ready, a missing bvalid, or an rdata word that changes while rready is low.
- A decode slip writes the wrong parameter output or returns a non-zero value from a reserved word.

The bench therefore reads every affected register straight after each stimulus and compares core_start and irq on the cycle they are due to change.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;

  // Byte offsets of the control words
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_GIE  = 'h04;
  localparam int OFS_IEN  = 'h08;
  localparam int OFS_ISTS = 'h0C;

  // Parameter words: first offset and stride between them
  localparam int OFS_PRM_BASE = 'h10;
  localparam int PRM_STRIDE   = 'h08;
  localparam int NUM_PRM      = 7;

  // Bit positions within the control word
  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_IDLE  = 2;
  localparam int B_READY = 3;
  localparam int B_AUTO  = 7;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/accel_rst_sync.sv
module accel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/accel_axil_wr.sv
module accel_axil_wr #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data
);
  logic              aw_held_q, aw_held_d;
  logic              w_held_q,  w_held_d;
  logic              bvalid_q,  bvalid_d;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] data_q;
  logic              aw_hs, w_hs, have_aw, have_w;
  logic              unused_aw_lsb;

  assign unused_aw_lsb = ^awaddr[1:0];

  assign awready = !aw_held_q && !bvalid_q;
  assign wready  = !w_held_q  && !bvalid_q;
  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid  && wready;
  assign have_aw = aw_held_q || aw_hs;
  assign have_w  = w_held_q  || w_hs;
  assign wr_en   = have_aw && have_w;
  assign wr_word = aw_held_q ? word_q : awaddr[ADDR_W-1:2];
  assign wr_data = w_held_q  ? data_q : wdata;
  assign bvalid  = bvalid_q;

  always_comb begin
    aw_held_d = aw_held_q;
    w_held_d  = w_held_q;
    bvalid_d  = bvalid_q;
    if (wr_en) begin
      aw_held_d = 1'b0;
      w_held_d  = 1'b0;
      bvalid_d  = 1'b1;
    end else begin
      if (aw_hs) aw_held_d = 1'b1;
      if (w_hs)  w_held_d  = 1'b1;
      if (bvalid_q && bready) bvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
    end else begin
      aw_held_q <= aw_held_d;
      w_held_q  <= w_held_d;
      bvalid_q  <= bvalid_d;
    end
  end

  // Payload capture, clock-enabled by the channel handshakes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      data_q <= '0;
    end else begin
      if (aw_hs) word_q <= awaddr[ADDR_W-1:2];
      if (w_hs)  data_q <= wdata;
    end
  end
endmodule

// File: rtl/accel_axil_rd.sv
module accel_axil_rd #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  input  logic [DATA_W-1:0] rd_value
);
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_ar_lsb;

  assign unused_ar_lsb = ^araddr[1:0];

  assign arready = !rvalid_q;
  assign rd_en   = arvalid && arready;
  assign rd_word = araddr[ADDR_W-1:2];
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;

  always_comb begin
    rvalid_d = rvalid_q;
    if (rd_en)                rvalid_d = 1'b1;
    else if (rvalid_q && rready) rvalid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_value;
  end
endmodule

// File: rtl/accel_ctrl_unit.sv
module accel_ctrl_unit
  import accel_regs_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  output logic              core_start,
  output logic              irq,
  output logic [DATA_W-1:0] ctrl_rdata
);
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(OFS_CTRL >> 2);
  localparam logic [WORD_W-1:0] W_GIE  = WORD_W'(OFS_GIE  >> 2);
  localparam logic [WORD_W-1:0] W_IEN  = WORD_W'(OFS_IEN  >> 2);
  localparam logic [WORD_W-1:0] W_ISTS = WORD_W'(OFS_ISTS >> 2);

  logic       start_q, start_d;
  logic       done_q,  done_d;
  logic       auto_q,  auto_d;
  logic       gie_q,   gie_d;
  logic [1:0] ien_q,   ien_d;
  logic [1:0] ists_q,  ists_d;
  logic       wr_ctrl, wr_gie, wr_ien, wr_ists, rd_ctrl;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  assign wr_ctrl = wr_en && (wr_word == W_CTRL);
  assign wr_gie  = wr_en && (wr_word == W_GIE);
  assign wr_ien  = wr_en && (wr_word == W_IEN);
  assign wr_ists = wr_en && (wr_word == W_ISTS);
  assign rd_ctrl = rd_en && (rd_word == W_CTRL);

  always_comb begin
    start_d = start_q;
    if (core_ready)                    start_d = 1'b0;
    if (wr_ctrl && wr_data[B_START])   start_d = 1'b1;
    if (auto_q && core_done)           start_d = 1'b1;

    auto_d = wr_ctrl ? wr_data[B_AUTO] : auto_q;

    done_d = done_q;
    if (rd_ctrl)   done_d = 1'b0;
    if (core_done) done_d = 1'b1;

    gie_d = wr_gie ? wr_data[0]   : gie_q;
    ien_d = wr_ien ? wr_data[1:0] : ien_q;

    ists_d = wr_ists ? (ists_q ^ wr_data[1:0]) : ists_q;
    if (core_done  && ien_q[0]) ists_d[0] = 1'b1;
    if (core_ready && ien_q[1]) ists_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ien_q   <= 2'b00;
      ists_q  <= 2'b00;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      auto_q  <= auto_d;
      gie_q   <= gie_d;
      ien_q   <= ien_d;
      ists_q  <= ists_d;
    end
  end

  assign core_start = start_q;
  assign irq        = gie_q && (|ists_q);

  always_comb begin
    ctrl_rdata = '0;
    unique case (rd_word)
      W_CTRL: begin
        ctrl_rdata[B_START] = start_q;
        ctrl_rdata[B_DONE]  = done_q;
        ctrl_rdata[B_IDLE]  = core_idle;
        ctrl_rdata[B_READY] = core_ready;
        ctrl_rdata[B_AUTO]  = auto_q;
      end
      W_GIE:   ctrl_rdata[0]   = gie_q;
      W_IEN:   ctrl_rdata[1:0] = ien_q;
      W_ISTS:  ctrl_rdata[1:0] = ists_q;
      default: ctrl_rdata = '0;
    endcase
  end
endmodule

// File: rtl/accel_param_bank.sv
module accel_param_bank
  import accel_regs_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wr_word,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [WORD_W-1:0]         rd_word,
  output logic [NUM_PRM*DATA_W-1:0] prm_flat,
  output logic [DATA_W-1:0]         prm_rdata
);
  logic [DATA_W-1:0] prm_q [NUM_PRM];

  for (genvar k = 0; k < NUM_PRM; k++) begin : g_prm
    localparam logic [WORD_W-1:0] W_K = WORD_W'((OFS_PRM_BASE + k*PRM_STRIDE) >> 2);
    logic hit;
    assign hit = wr_en && (wr_word == W_K);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prm_q[k] <= '0;
      else if (hit) prm_q[k] <= wr_data;
    end

    assign prm_flat[k*DATA_W +: DATA_W] = prm_q[k];
  end

  always_comb begin
    prm_rdata = '0;
    for (int k = 0; k < NUM_PRM; k++) begin
      if (rd_word == WORD_W'((OFS_PRM_BASE + k*PRM_STRIDE) >> 2)) prm_rdata = prm_q[k];
    end
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_regs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              core_start,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  output logic              irq,
  output logic [DATA_W-1:0] cfg_width,
  output logic [DATA_W-1:0] cfg_height,
  output logic [DATA_W-1:0] cfg_lvl_red,
  output logic [DATA_W-1:0] cfg_lvl_blue,
  output logic [DATA_W-1:0] cfg_lvl_gred,
  output logic [DATA_W-1:0] cfg_lvl_gblue,
  output logic [DATA_W-1:0] cfg_pattern
);
  localparam int WORD_W = ADDR_W - 2;

  logic                      rst_n_s;
  logic                      wr_en, rd_en;
  logic [WORD_W-1:0]         wr_word, rd_word;
  logic [DATA_W-1:0]         wr_data, ctrl_rdata, prm_rdata, rd_value;
  logic [NUM_PRM*DATA_W-1:0] prm_flat;

  accel_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  accel_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n_s),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data)
  );

  accel_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n_s),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
    .rd_en(rd_en), .rd_word(rd_word), .rd_value(rd_value)
  );

  accel_ctrl_unit #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .rd_en(rd_en), .rd_word(rd_word),
    .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready),
    .core_start(core_start), .irq(irq), .ctrl_rdata(ctrl_rdata)
  );

  accel_param_bank #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_prm (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .rd_word(rd_word), .prm_flat(prm_flat), .prm_rdata(prm_rdata)
  );

  // Each source returns zero outside its own words
  assign rd_value = ctrl_rdata | prm_rdata;
  assign s_bresp  = RESP_OKAY;
  assign s_rresp  = RESP_OKAY;

  assign cfg_width     = prm_flat[0*DATA_W +: DATA_W];
  assign cfg_height    = prm_flat[1*DATA_W +: DATA_W];
  assign cfg_lvl_red   = prm_flat[2*DATA_W +: DATA_W];
  assign cfg_lvl_blue  = prm_flat[3*DATA_W +: DATA_W];
  assign cfg_lvl_gred  = prm_flat[4*DATA_W +: DATA_W];
  assign cfg_lvl_gblue = prm_flat[5*DATA_W +: DATA_W];
  assign cfg_pattern   = prm_flat[6*DATA_W +: DATA_W];
endmodule

// File: rtl/accel_ctrl_regs_chk.sv
module accel_ctrl_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awready,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              core_start,
  input logic              core_done,
  input logic              core_ready,
  input logic              irq
);
  assert_bvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);

  assert_no_accept_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready && !s_wready);

  assert_bresp_okay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == 2'b00);

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  assert_rresp_okay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00);

  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_start) |-> $past(core_ready));

  assert_start_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_start) |-> $rose(s_bvalid) || $past(core_done));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(s_bvalid) || $past(core_done) || $past(core_ready));
endmodule

bind accel_ctrl_regs accel_ctrl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .core_start(core_start), .core_done(core_done), .core_ready(core_ready),
  .irq(irq)
);

// File: tb/accel_ctrl_regs_bench.sv
module accel_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              s_awvalid, s_awready, s_wvalid, s_wready;
  logic [ADDR_W-1:0] s_awaddr, s_araddr;
  logic [DATA_W-1:0] s_wdata, s_rdata;
  logic              s_bvalid, s_bready, s_arvalid, s_arready, s_rvalid, s_rready;
  logic [1:0]        s_bresp, s_rresp;
  logic              core_start, core_done, core_idle, core_ready, irq;
  logic [DATA_W-1:0] cfg_width, cfg_height, cfg_lvl_red, cfg_lvl_blue;
  logic [DATA_W-1:0] cfg_lvl_gred, cfg_lvl_gblue, cfg_pattern;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_accel_ctrl_regs (.*);

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard whenever a read completes
  always @(negedge clk) begin
    if (rst_n && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected read data", s_rdata, '0);
        n_err++;
      end else begin
        check(tag_q.pop_front(), s_rdata, exp_q.pop_front());
        check("R3 rresp okay", {30'd0, s_rresp}, 32'd0);
      end
    end
  end

  // Driver: issues a read, pushes its expected data, optionally stalls rready
  task automatic axi_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input string tag, input int hold);
    step();
    s_araddr = a; s_arvalid = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    step();
    s_arvalid = 1'b0;
    repeat (hold) step();
    s_rready = 1'b1;
    step();
    s_rready = 1'b0;
  endtask

  // mode 0: same cycle, 1: address first, 2: data first
  task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int mode);
    step();
    s_awaddr = a; s_wdata = d;
    if (mode == 0) begin
      s_awvalid = 1'b1; s_wvalid = 1'b1;
      step();
      s_awvalid = 1'b0; s_wvalid = 1'b0;
    end else if (mode == 1) begin
      s_awvalid = 1'b1;
      step();
      s_awvalid = 1'b0;
      @(negedge clk);
      check("R2 awready low while address held", {31'd0, s_awready}, 32'd0);
      check("R2 no response before data", {31'd0, s_bvalid}, 32'd0);
      step();
      s_wvalid = 1'b1;
      step();
      s_wvalid = 1'b0;
    end else begin
      s_wvalid = 1'b1;
      step();
      s_wvalid = 1'b0;
      @(negedge clk);
      check("R2 wready low while data held", {31'd0, s_wready}, 32'd0);
      check("R2 no response before address", {31'd0, s_bvalid}, 32'd0);
      step();
      s_awvalid = 1'b1;
      step();
      s_awvalid = 1'b0;
    end
    @(negedge clk);
    check("R2 bvalid after both channels", {31'd0, s_bvalid}, 32'd1);
    check("R2 bresp okay", {30'd0, s_bresp}, 32'd0);
    step();
    check("R2 bvalid held without bready", {31'd0, s_bvalid}, 32'd1);
    s_bready = 1'b1;
    step();
    s_bready = 1'b0;
    @(negedge clk);
    check("R2 bvalid cleared by bready", {31'd0, s_bvalid}, 32'd0);
  endtask

  task automatic pulse_done();
    step(); core_done = 1'b1; step(); core_done = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_ready();
    step(); core_ready = 1'b1; step(); core_ready = 1'b0; @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] cfg_of(input int k);
    case (k)
      0: return cfg_width;
      1: return cfg_height;
      2: return cfg_lvl_red;
      3: return cfg_lvl_blue;
      4: return cfg_lvl_gred;
      5: return cfg_lvl_gblue;
      default: return cfg_pattern;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_bready = 0; s_rready = 0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0;
    core_done = 0; core_ready = 0; core_idle = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    // R1 reset state
    check("R1 core_start low", {31'd0, core_start}, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);
    check("R1 ready signals high", {29'd0, s_awready, s_wready, s_arready}, 32'd7);
    check("R1 no responses pending", {30'd0, s_bvalid, s_rvalid}, 32'd0);
    axi_read(7'h00, 32'h4, "R1 control word idle only", 0);
    axi_read(7'h10, 32'h0, "R1 width zero", 0);
    axi_read(7'h0C, 32'h0, "R1 status zero", 0);

    // R4 + R2: parameter writes in every channel order, readback with stalls (R3)
    for (int k = 0; k < 7; k++)
      axi_write(7'(8'h10 + 8*k), 32'hA5000000 ^ (32'h01010101 * k) ^ k, k % 3);
    for (int k = 0; k < 7; k++) begin
      check("R4 parameter output", cfg_of(k), 32'hA5000000 ^ (32'h01010101 * k) ^ k);
      axi_read(7'(8'h10 + 8*k), 32'hA5000000 ^ (32'h01010101 * k) ^ k, "R4 R3 parameter readback", k % 4);
    end

    // R5 reserved and unmapped words
    axi_write(7'h14, 32'hFFFFFFFF, 0);
    axi_write(7'h44, 32'hFFFFFFFF, 1);
    axi_write(7'h7C, 32'hFFFFFFFF, 2);
    @(negedge clk);
    check("R5 width untouched by 0x14 write", cfg_width, 32'hA5000000);
    check("R5 pattern untouched by 0x44 write", cfg_pattern, 32'hA5000000 ^ (32'h01010101 * 6) ^ 6);
    axi_read(7'h14, 32'h0, "R5 reserved 0x14 reads zero", 0);
    axi_read(7'h44, 32'h0, "R5 unmapped 0x44 reads zero", 0);
    axi_read(7'h7C, 32'h0, "R5 unmapped 0x7C reads zero", 1);
    axi_read(7'h0C, 32'h0, "R5 status untouched", 0);

    // R6 start handshake
    axi_write(7'h00, 32'h0, 0);
    check("R6 writing zero keeps start low", {31'd0, core_start}, 32'd0);
    axi_write(7'h00, 32'h1, 1);
    check("R6 start set by write", {31'd0, core_start}, 32'd1);
    axi_write(7'h00, 32'h0, 2);
    check("R6 writing zero does not clear start", {31'd0, core_start}, 32'd1);
    axi_read(7'h00, 32'h5, "R6 control reads start and idle", 0);
    step(); core_ready = 1'b1;
    @(negedge clk);
    check("R6 start held until ready sampled", {31'd0, core_start}, 32'd1);
    step(); core_ready = 1'b0;
    @(negedge clk);
    check("R6 start cleared by ready", {31'd0, core_start}, 32'd0);

    // R8 done flag
    pulse_done();
    axi_read(7'h00, 32'h6, "R8 done set, read returns it", 0);
    axi_read(7'h00, 32'h4, "R8 done cleared by read", 0);
    step(); core_ready = 1'b1;
    axi_read(7'h00, 32'hC, "R8 live ready bit", 0);
    core_ready = 1'b0;
    core_idle = 1'b0;
    axi_read(7'h00, 32'h0, "R8 live idle bit low", 0);
    core_idle = 1'b1;
    step(); core_done = 1'b1;
    axi_read(7'h00, 32'h6, "R8 done seen while held", 0);
    core_done = 1'b0;
    axi_read(7'h00, 32'h6, "R8 set wins over read clear", 0);
    axi_read(7'h00, 32'h4, "R8 cleared afterwards", 0);

    // R7 auto restart
    axi_write(7'h00, 32'h80, 0);
    axi_read(7'h00, 32'h84, "R7 auto bit reads back", 0);
    pulse_done();
    check("R7 done rearms start", {31'd0, core_start}, 32'd1);
    axi_read(7'h00, 32'h87, "R7 start done idle auto", 0);
    pulse_ready();
    check("R7 ready clears rearmed start", {31'd0, core_start}, 32'd0);
    axi_write(7'h00, 32'h0, 1);
    pulse_done();
    check("R7 no rearm with auto clear", {31'd0, core_start}, 32'd0);
    axi_read(7'h00, 32'h6, "R7 auto cleared", 0);
    axi_read(7'h00, 32'h4, "R8 done cleared again", 0);

    // R9 R10 R11 interrupts
    axi_write(7'h04, 32'h1, 0);
    axi_read(7'h04, 32'h1, "R9 global enable readback", 0);
    pulse_done();
    check("R11 irq low with sources disabled", {31'd0, irq}, 32'd0);
    axi_read(7'h0C, 32'h0, "R10 done gated by enable", 0);
    axi_write(7'h08, 32'h3, 2);
    axi_read(7'h08, 32'h3, "R9 source enables readback", 0);
    pulse_done();
    check("R11 irq from done", {31'd0, irq}, 32'd1);
    axi_read(7'h0C, 32'h1, "R10 done status set", 0);
    axi_write(7'h0C, 32'h1, 0);
    check("R11 irq low after toggle", {31'd0, irq}, 32'd0);
    axi_read(7'h0C, 32'h0, "R10 toggle clears done status", 0);
    pulse_ready();
    check("R11 irq from ready", {31'd0, irq}, 32'd1);
    axi_read(7'h0C, 32'h2, "R10 ready status set", 0);
    axi_write(7'h04, 32'h0, 1);
    check("R11 irq masked by global enable", {31'd0, irq}, 32'd0);
    axi_write(7'h04, 32'h1, 0);
    check("R11 irq returns with enable", {31'd0, irq}, 32'd1);
    axi_write(7'h0C, 32'h3, 0);
    axi_read(7'h0C, 32'h1, "R10 write of ones inverts both bits", 0);
    axi_write(7'h0C, 32'h0, 0);
    axi_read(7'h0C, 32'h1, "R10 write of zero keeps bits", 0);
    axi_write(7'h0C, 32'h1, 2);
    check("R11 irq low when status empty", {31'd0, irq}, 32'd0);

    repeat (3) step();
    check("R3 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule